// File: doc/BRIEF.md
# Double-Buffered Matrix Transposer

This block takes a serial stream of square matrix frames, one element per clock when the input strobe is high, in row-major order. It returns every frame serially in column-major order, so that a later stage sees the transpose. The default matrix is 8x8, which gives 64 elements per frame. The element width is a parameter. In a two-pass transform the width is set to the first pass's output width.

Two storage banks take turns. One bank collects the incoming frame while the other bank is read out. The roles swap on the clock that writes the last element of a frame. Readout of a completed frame starts on the next clock, so an unbroken input stream produces an unbroken output stream. There is a fixed 65-clock delay from the first element in to the first element out.

Top module: `mtx_transpose_pp`

## Requirements
- R1: While `rst_n` is low, `out_vld` is 0 and `out_dat` is 0. An asynchronous reset also discards any partly collected frame and any readout that is pending.
- R2: Element k of an output frame (k = 0..63) is the input element at row k mod 8, column k div 8. Input element index i = row*8 + col is the count of accepted elements within the frame.
- R3: When a frame arrives with the strobe held high, its first output element appears exactly 65 rising edges after the edge that accepts its first input element.
- R4: Each completed frame produces exactly 64 consecutive clocks of `out_vld` high.
- R5: If frames arrive back to back with no idle clock, `out_vld` stays high without a gap across all of them, and every element is correct.
- R6: A clock with `in_vld` low is ignored. It neither advances the frame position nor starts a readout. A frame with idle clocks completes only after its 64th accepted element, and its output is still correct.
- R7: `out_dat` keeps its value on every clock where `out_vld` is low.
- R8: Writing a frame into one bank never corrupts the frame being read from the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input element strobe |
| in_dat | input | DATA_W | Input element, row-major order |
| out_vld | output | 1 | Output element strobe |
| out_dat | output | DATA_W | Output element, column-major order |

## Verification
There is one clock where two things happen together. The last read of the bank being drained falls on the same clock as the last write into the other bank. On that clock the read counter must restart on the other bank and must not stop. The bench provokes this clock by sending three frames back to back with no idle clock between them. It then checks that `out_vld` forms a single run of 192 clocks, and that every element equals the transposed index pattern it computes itself. A separate frame with idle clocks spread through it shows the opposite case: the readout waits until the 64th accepted element, so these two events never meet.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Number of banks that alternate between collecting and draining.
    localparam int unsigned TP_NBANK = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

endpackage

// File: rtl/tp_addr_swap.sv
// Turns a column-major output index into the row-major storage address.
// The two halves of the index swap places.
module tp_addr_swap #(
    parameter int unsigned LG = 3
) (
    input  logic [2*LG-1:0] idx,
    output logic [2*LG-1:0] addr
);
    localparam int unsigned AW = 2 * LG;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign addr[i] = idx[(i + LG) % AW];
    end
endmodule

// File: rtl/tp_bank.sv
// One storage bank: a write port and a registered read port.
module tp_bank #(
    parameter int unsigned DATA_W = 11,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tp_ctrl.sv
// Frame counting, bank role swap and read sequencing.
module tp_ctrl
    import tp_pkg::*;
#(
    parameter int unsigned LG = 3,
    localparam int unsigned AW = 2 * LG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    output logic [AW-1:0] wr_cnt,
    output bank_e         wr_sel,
    output logic          rd_act,
    output logic [AW-1:0] rd_cnt,
    output bank_e         rd_sel,
    output logic          pipe_vld,
    output bank_e         pipe_sel
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] wr_cnt;
        bank_e         wr_sel;
        logic          rd_act;
        logic [AW-1:0] rd_cnt;
        bank_e         rd_sel;
        logic          pipe_vld;
        bank_e         pipe_sel;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  wr_done;

    always_comb begin
        st_d    = st_q;
        wr_done = in_vld && (st_q.wr_cnt == LAST);

        if (in_vld) begin
            st_d.wr_cnt = st_q.wr_cnt + 1'b1;
        end

        if (wr_done) begin
            st_d.wr_sel = bank_e'(~st_q.wr_sel);
            st_d.rd_sel = st_q.wr_sel;
            st_d.rd_act = 1'b1;
            st_d.rd_cnt = '0;
        end else if (st_q.rd_act) begin
            if (st_q.rd_cnt == LAST) begin
                st_d.rd_act = 1'b0;
            end
            st_d.rd_cnt = st_q.rd_cnt + 1'b1;
        end

        st_d.pipe_vld = st_q.rd_act;
        st_d.pipe_sel = st_q.rd_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_cnt: '0, wr_sel: BANK_A, rd_act: 1'b0, rd_cnt: '0,
                      rd_sel: BANK_A, pipe_vld: 1'b0, pipe_sel: BANK_A};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_cnt   = st_q.wr_cnt;
    assign wr_sel   = st_q.wr_sel;
    assign rd_act   = st_q.rd_act;
    assign rd_cnt   = st_q.rd_cnt;
    assign rd_sel   = st_q.rd_sel;
    assign pipe_vld = st_q.pipe_vld;
    assign pipe_sel = st_q.pipe_sel;
endmodule

// File: rtl/mtx_transpose_pp.sv
module mtx_transpose_pp
    import tp_pkg::*;
#(
    parameter int unsigned DATA_W = 11,
    parameter int unsigned DIM    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat
);
    localparam int unsigned LG    = $clog2(DIM);
    localparam int unsigned AW    = 2 * LG;
    localparam int unsigned DEPTH = DIM * DIM;

    logic [AW-1:0] wr_cnt;
    logic [AW-1:0] rd_cnt;
    logic [AW-1:0] rd_addr;
    logic          rd_act;
    logic          pipe_vld;
    bank_e         wr_sel, rd_sel, pipe_sel;

    logic [DATA_W-1:0] bank_rd [TP_NBANK];

    tp_ctrl #(.LG(LG)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .wr_cnt   (wr_cnt),
        .wr_sel   (wr_sel),
        .rd_act   (rd_act),
        .rd_cnt   (rd_cnt),
        .rd_sel   (rd_sel),
        .pipe_vld (pipe_vld),
        .pipe_sel (pipe_sel)
    );

    tp_addr_swap #(.LG(LG)) u_swap (
        .idx  (rd_cnt),
        .addr (rd_addr)
    );

    for (genvar b = 0; b < TP_NBANK; b++) begin : g_bank
        tp_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (in_vld && (wr_sel == bank_e'(b))),
            .waddr (wr_cnt),
            .wdata (in_dat),
            .re    (rd_act && (rd_sel == bank_e'(b))),
            .raddr (rd_addr),
            .rdata (bank_rd[b])
        );
    end

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = pipe_vld;
        if (pipe_vld) begin
            out_d.dat = bank_rd[pipe_sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_vld = out_q.vld;
    assign out_dat = out_q.dat;
endmodule

// File: rtl/mtx_transpose_pp_chk.sv
module mtx_transpose_pp_chk #(
    parameter int unsigned DATA_W = 11,
    parameter int unsigned DIM    = 8,
    localparam int unsigned AW    = 2 * $clog2(DIM),
    localparam int unsigned DEPTH = DIM * DIM
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [AW-1:0]     wr_cnt,
    input logic              rd_act,
    input logic [AW-1:0]     rd_cnt,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_dat
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (out_vld) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_IDLE: assert (!out_vld && out_dat == '0); // R1
        end
    end

    AST_FIRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_cnt == '0) |=> ##1 out_vld); // R3

    AST_RUN_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_vld) |-> (run_q % DEPTH == 0)); // R4

    AST_FRAME_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && wr_cnt == {AW{1'b1}}) |=> (rd_act && rd_cnt == '0)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(wr_cnt)); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_dat)); // R7
endmodule

bind mtx_transpose_pp mtx_transpose_pp_chk #(.DATA_W(DATA_W), .DIM(DIM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .wr_cnt  (wr_cnt),
    .rd_act  (rd_act),
    .rd_cnt  (rd_cnt),
    .out_vld (out_vld),
    .out_dat (out_dat)
);

// File: tb/sim_mtx_transpose_pp.sv
`timescale 1ns/1ps
module sim_mtx_transpose_pp;
    localparam int unsigned W = 11;
    localparam int unsigned N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [W-1:0] in_dat = '0;
    logic         out_vld;
    logic [W-1:0] out_dat;

    int unsigned vectors = 0;
    int unsigned errors  = 0;
    int unsigned cyc     = 0;
    int unsigned out_idx = 0;
    int unsigned out_tot = 0;
    int unsigned run_cur = 0;
    int unsigned run_last = 0;
    int unsigned first_out_cyc = 0;
    bit          seen_first = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mtx_transpose_pp #(.DATA_W(W), .DIM(8)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
        .out_vld(out_vld), .out_dat(out_dat)
    );

    function automatic logic [W-1:0] pat(int unsigned f, int unsigned a);
        return W'((f * 41 + a * 3 + 7) % (1 << W));
    endfunction

    task automatic check(bit ok, string req, int unsigned act, int unsigned exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Output monitor: R2, R8 data check and run tracking
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                int unsigned f, k;
                f = out_idx / N;
                k = out_idx % N;
                check(out_dat == pat(f, (k % 8) * 8 + k / 8), "R2/R8 transpose",
                      out_dat, pat(f, (k % 8) * 8 + k / 8));
                if (!seen_first) begin
                    seen_first    = 1'b1;
                    first_out_cyc = cyc;
                end
                out_idx++;
                out_tot++;
                run_cur++;
            end else if (run_cur != 0) begin
                run_last = run_cur;
                run_cur  = 0;
            end
        end
    end

    task automatic send_frame(int unsigned f, bit gaps);
        for (int a = 0; a < N; a++) begin
            if (gaps && (a % 2 == 1 || a == N - 1)) begin
                @(negedge clk);
                in_vld = 1'b0;
                in_dat = '1;
                @(negedge clk);
                in_vld = 1'b0;
            end
            @(negedge clk);
            in_vld = 1'b1;
            in_dat = pat(f, a);
        end
    endtask

    task automatic idle(int unsigned n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_dat = '0;
        end
    endtask

    initial begin
        int unsigned c0;
        int unsigned tot0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_vld == 1'b0, "R1 vld in reset", out_vld, 0);
        check(out_dat == '0, "R1 dat in reset", out_dat, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3, R5: three frames back to back
        @(negedge clk);
        c0 = cyc;
        in_vld = 1'b1;
        in_dat = pat(0, 0);
        for (int a = 1; a < N; a++) begin
            @(negedge clk);
            in_dat = pat(0, a);
        end
        send_frame(1, 1'b0);
        send_frame(2, 1'b0);
        idle(N + 10);
        check(first_out_cyc - c0 == 66, "R3 latency", first_out_cyc - c0, 66);
        check(run_last == 3 * N, "R5 unbroken run", run_last, 3 * N);
        check(out_tot == 3 * N, "R4 output count", out_tot, 3 * N);

        // R6: frame with idle clocks
        tot0 = out_tot;
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            in_vld = 1'b0;
            @(negedge clk);
            if (a == N - 1) begin
                check(out_tot == tot0, "R6 no early readout", out_tot, tot0);
            end
            in_vld = 1'b1;
            in_dat = pat(3, a);
            if (a % 5 == 0) begin
                idle(3);
            end
        end
        idle(N + 10);
        check(out_tot == tot0 + N, "R6 gapped frame count", out_tot, tot0 + N);
        check(run_last == N, "R4 single-frame run", run_last, N);
        check(!out_vld, "R4 vld drops after frame", out_vld, 0);
        check(out_dat == pat(3, 63), "R7 data held", out_dat, pat(3, 63));
        idle(5);
        check(out_dat == pat(3, 63), "R7 data held later", out_dat, pat(3, 63));

        // R1: reset mid-frame discards the partial frame
        for (int a = 0; a < 30; a++) begin
            @(negedge clk);
            in_vld = 1'b1;
            in_dat = pat(9, a);
        end
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b0;
        #1;
        check(out_vld == 1'b0, "R1 vld after reset", out_vld, 0);
        check(out_dat == '0, "R1 dat after reset", out_dat, 0);
        @(negedge clk);
        rst_n   = 1'b1;
        out_idx = 4 * N;
        tot0    = out_tot;
        send_frame(4, 1'b0);
        idle(N + 10);
        check(out_tot == tot0 + N, "R1 fresh frame after reset", out_tot, tot0 + N);
        check(run_last == N, "R4 run after reset", run_last, N);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule